// File: doc/BRIEF.md
# Iterative Round-Robin Crossbar Matcher

This block computes a crossbar configuration for an N x N switch whose inputs keep one virtual output queue per output. After a start strobe it latches an N x N request matrix and runs request/grant/accept iterations, one per clock cycle. In each iteration every still-free output grants one requesting free input, and every free input accepts one of the grants it received. The accepted pairs are added to the match and their ports take no part in later iterations.

Every output has a round-robin grant pointer and every input a round-robin accept pointer. The pointers persist across schedules. They advance only when a grant is accepted in the first iteration, and they then move one position past the port just served. The port served most recently therefore gets the lowest priority next time. Under sustained full load this pushes the output pointers apart, and one iteration then yields a complete match.

The number of iterations can be set from 1 to N. A run also ends early when an iteration adds no pair. A one-cycle done pulse marks the point at which the match output holds the final result. Queue storage and the data path are outside this block.

Top module: `islip_sched`

## Requirements
- R1: In each iteration, output j grants the first input i, searching i = gptr[j], gptr[j]+1, ... modulo N, for which request bit i*N+j is set and both input i and output j are still unmatched.
- R2: Input i accepts the first output j, searching j = aptr[i], aptr[i]+1, ... modulo N, that granted it in the same iteration.
- R3: `match_flat` bit i*N+j set means input i is connected to output j. Each input and each output has at most one set bit, and every set bit has its request bit set.
- R4: An iteration only adds pairs between ports still unmatched, and pairs already found are never removed during a run.
- R5: A `start` seen while idle latches `req_flat` and `iter_cfg` and clears the match. The limit is 1 when `iter_cfg` is 0, N when it exceeds N, and `iter_cfg` otherwise. One iteration runs per cycle until the limit is reached or an iteration adds no pair. If start is sampled at edge k and m iterations run, `done` is high for exactly the cycle after edge k+m, and `match_flat` then holds its value until the next accepted start.
- R6: Only pairs accepted in the first iteration move pointers. For pair (i,j), grant pointer j becomes (i+1) mod N and accept pointer i becomes (j+1) mod N. All other pointers keep their values, and all pointers carry over to the next schedule.
- R7: After reset, `done` is low, `match_flat` is zero and every pointer is zero.
- R8: A `start` while a run is in progress is ignored: it neither changes the latched requests nor starts another run.
- R9: With a limit of N, the final match is maximal: no requested pair has both its input and its output unmatched.
- R10: With N=4, all requests set and a limit of 1 from reset, the first schedule matches only input 0 to output 0, and from the fourth schedule on every schedule matches all four inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start a schedule (taken only while idle) |
| iter_cfg | input | $clog2(N+1) | Iteration limit, 0 treated as 1, clamped to N |
| req_flat | input | N*N | Request matrix, bit i*N+j: input i wants output j |
| match_flat | output | N*N | Match matrix, bit i*N+j: input i connected to output j |
| done | output | 1 | One-cycle pulse when the match is final |

## Verification
Sparse, dense and full-load pseudo-random request matrices are combined with every iteration setting from 0 to above N. Sparse matrices show whether the cyclic search wraps past the pointer correctly. Dense ones separate early termination from a run that reaches its limit, and they test maximality. Repeated full-load schedules with a single iteration show whether the pointers move only on accepted first-iteration grants, because only correct updates give the expected progression to a complete match. Empty, single-bit and diagonal matrices cover the edges of the search and the one-iteration stop, and a start injected mid-run shows that a busy scheduler keeps its latched requests.

// File: rtl/islip_pkg.sv
package islip_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sched_st_e;

    // Maps a requested iteration count onto the legal range 1..n.
    function automatic int clamp_iters(input int cfg, input int n);
        if (cfg <= 0) begin
            return 1;
        end
        if (cfg > n) begin
            return n;
        end
        return cfg;
    endfunction

endpackage

// File: rtl/islip_rr_pick.sv
// Programmable priority encoder: picks the first candidate at or after ptr.
module islip_rr_pick #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0]  cand,
    input  logic [PW-1:0] ptr,
    output logic [N-1:0]  pick
);

    int   idx;
    logic found;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        idx   = 0;
        for (int k = 0; k < N; k++) begin
            idx = (int'(ptr) + k) % N;
            if (!found && cand[idx]) begin
                pick[idx] = 1'b1;
                found     = 1'b1;
            end
        end
    end

    always_comb begin
        if (!$isunknown(cand) && !$isunknown(ptr)) begin
            a_r1_pick_single: assert ($onehot0(pick));
            a_r1_pick_when_any: assert ((|cand) == (|pick));
            a_r1_pick_in_cand: assert ((pick & ~cand) == '0);
        end
    end

endmodule

// File: rtl/islip_iter.sv
// One request/grant/accept iteration over the eligible request matrix.
module islip_iter #(
    parameter int N  = 4,
    parameter int PW = 2
) (
    input  logic [N-1:0][N-1:0]  elig,
    input  logic [N-1:0][PW-1:0] gptr,
    input  logic [N-1:0][PW-1:0] aptr,
    output logic [N-1:0][N-1:0]  pairs
);

    logic [N-1:0] col_req [N];
    logic [N-1:0] gsel    [N];
    logic [N-1:0] offer   [N];
    logic [N-1:0] asel    [N];

    // Column view: which inputs request output j.
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                col_req[j][i] = elig[i][j];
            end
        end
    end

    for (genvar j = 0; j < N; j++) begin : g_grant
        islip_rr_pick #(.N(N), .PW(PW)) u_gpick (
            .cand (col_req[j]),
            .ptr  (gptr[j]),
            .pick (gsel[j])
        );
    end

    // Row view: which outputs granted input i.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                offer[i][j] = gsel[j][i];
            end
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_accept
        islip_rr_pick #(.N(N), .PW(PW)) u_apick (
            .cand (offer[i]),
            .ptr  (aptr[i]),
            .pick (asel[i])
        );
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            pairs[i] = asel[i];
        end
    end

endmodule

// File: rtl/islip_sched.sv
module islip_sched #(
    parameter int N  = 4,
    parameter int PW = (N > 1) ? $clog2(N) : 1,
    parameter int IW = $clog2(N + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IW-1:0]   iter_cfg,
    input  logic [N*N-1:0]  req_flat,
    output logic [N*N-1:0]  match_flat,
    output logic            done
);

    import islip_pkg::*;

    typedef struct packed {
        sched_st_e             st;
        logic                  done;
        logic [IW-1:0]         iter_cnt;
        logic [IW-1:0]         iter_lim;
        logic [N-1:0][N-1:0]   req;
        logic [N-1:0][N-1:0]   match;
        logic [N-1:0][PW-1:0]  gptr;
        logic [N-1:0][PW-1:0]  aptr;
    } state_t;

    state_t s_q, s_d;

    logic [N-1:0]         in_free;
    logic [N-1:0]         out_free;
    logic [N-1:0][N-1:0]  elig;
    logic [N-1:0][N-1:0]  new_pairs;
    logic [IW-1:0]        nxt_cnt;

    // Ports still free in the current run.
    always_comb begin
        for (int i = 0; i < N; i++) begin
            in_free[i] = ~|s_q.match[i];
        end
        for (int j = 0; j < N; j++) begin
            out_free[j] = 1'b1;
            for (int i = 0; i < N; i++) begin
                if (s_q.match[i][j]) begin
                    out_free[j] = 1'b0;
                end
            end
        end
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                elig[i][j] = s_q.req[i][j] & in_free[i] & out_free[j];
            end
        end
    end

    islip_iter #(.N(N), .PW(PW)) u_iter (
        .elig  (elig),
        .gptr  (s_q.gptr),
        .aptr  (s_q.aptr),
        .pairs (new_pairs)
    );

    assign nxt_cnt = s_q.iter_cnt + 1'b1;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_IDLE: begin
                if (start) begin
                    s_d.st       = ST_RUN;
                    s_d.req      = req_flat;
                    s_d.match    = '0;
                    s_d.iter_cnt = '0;
                    s_d.iter_lim = IW'(clamp_iters(int'(iter_cfg), N));
                end
            end
            default: begin
                s_d.match    = s_q.match | new_pairs;
                s_d.iter_cnt = nxt_cnt;
                if (s_q.iter_cnt == '0) begin
                    for (int i = 0; i < N; i++) begin
                        for (int j = 0; j < N; j++) begin
                            if (new_pairs[i][j]) begin
                                s_d.gptr[j] = PW'((i + 1) % N);
                                s_d.aptr[i] = PW'((j + 1) % N);
                            end
                        end
                    end
                end
                if ((nxt_cnt == s_q.iter_lim) || (new_pairs == '0)) begin
                    s_d.st   = ST_IDLE;
                    s_d.done = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st       <= ST_IDLE;
            s_q.done     <= 1'b0;
            s_q.iter_cnt <= '0;
            s_q.iter_lim <= IW'(1);
            s_q.req      <= '0;
            s_q.match    <= '0;
            s_q.gptr     <= '0;
            s_q.aptr     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign match_flat = s_q.match;
    assign done       = s_q.done;

    // ---------------- assertions ----------------
    logic [N-1:0] match_col [N];
    always_comb begin
        for (int j = 0; j < N; j++) begin
            for (int i = 0; i < N; i++) begin
                match_col[j][i] = s_q.match[i][j];
            end
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_chk
        a_r3_row_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(s_q.match[g]));
        a_r3_col_single: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(match_col[g]));
    end

    a_r3_match_requested: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.match & ~s_q.req) == '0);

    a_r4_match_grows: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN) |=> ((s_q.match & $past(s_q.match)) == $past(s_q.match)));

    a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r5_done_ends_run: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (s_q.st == ST_IDLE));

    a_r5_iter_bound: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.iter_cnt <= s_q.iter_lim);

    a_r6_ptr_hold_late: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN && s_q.iter_cnt != '0) |=> ($stable(s_q.gptr) && $stable(s_q.aptr)));

    a_r6_ptr_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_IDLE) |=> ($stable(s_q.gptr) && $stable(s_q.aptr)));

    a_r8_busy_keeps_req: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ST_RUN) |=> $stable(s_q.req));

endmodule

// File: tb/islip_sched_test.sv
`timescale 1ns/1ps
module islip_sched_test;

    localparam int N  = 4;
    localparam int IW = $clog2(N + 1);
    localparam int NN = N * N;

    logic           clk = 1'b0;
    logic           rst_n;
    logic           start;
    logic [IW-1:0]  iter_cfg;
    logic [NN-1:0]  req_flat;
    logic [NN-1:0]  match_flat;
    logic           done;

    int n_chk  = 0;
    int n_fail = 0;
    int wd     = 0;

    int gp [N];
    int ap [N];
    logic [31:0] lcg = 32'h1234_5678;

    always #4 clk = ~clk;

    islip_sched #(.N(N)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .iter_cfg   (iter_cfg),
        .req_flat   (req_flat),
        .match_flat (match_flat),
        .done       (done)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int popc(input logic [NN-1:0] v);
        int c = 0;
        for (int b = 0; b < NN; b++) c += int'(v[b]);
        return c;
    endfunction

    // Reference of R1/R2/R4/R5/R6: returns expected match and iterations run.
    task automatic model(input logic [NN-1:0] rq, input int cfg,
                         output logic [NN-1:0] m, output int iters);
        int lim;
        int gsel [N];
        logic [NN-1:0] add;
        lim   = (cfg <= 0) ? 1 : ((cfg > N) ? N : cfg);
        m     = '0;
        iters = 0;
        for (int it = 0; it < lim; it++) begin
            add = '0;
            for (int j = 0; j < N; j++) begin
                gsel[j] = -1;
                for (int k = 0; k < N; k++) begin
                    int i = (gp[j] + k) % N;
                    bit ifree = 1'b1;
                    bit ofree = 1'b1;
                    for (int x = 0; x < N; x++) begin
                        if (m[i*N+x]) ifree = 1'b0;
                        if (m[x*N+j]) ofree = 1'b0;
                    end
                    if (gsel[j] < 0 && rq[i*N+j] && ifree && ofree) gsel[j] = i;
                end
            end
            for (int i = 0; i < N; i++) begin
                bit took = 1'b0;
                for (int k = 0; k < N; k++) begin
                    int j = (ap[i] + k) % N;
                    if (!took && gsel[j] == i) begin
                        add[i*N+j] = 1'b1;
                        took = 1'b1;
                    end
                end
            end
            if (it == 0) begin
                for (int i = 0; i < N; i++)
                    for (int j = 0; j < N; j++)
                        if (add[i*N+j]) begin
                            gp[j] = (i + 1) % N;
                            ap[i] = (j + 1) % N;
                        end
            end
            m = m | add;
            iters++;
            if (add == '0) break;
        end
    endtask

    // Runs one schedule, optionally injecting a start while busy (R8).
    task automatic sched(input logic [NN-1:0] rq, input int cfg, input bit inject,
                         output logic [NN-1:0] got);
        logic [NN-1:0] em;
        int ei;
        int cyc = 0;
        int lim;
        bit bad;
        model(rq, cfg, em, ei);
        lim = (cfg <= 0) ? 1 : ((cfg > N) ? N : cfg);
        @(negedge clk);
        start    = 1'b1;
        req_flat = rq;
        iter_cfg = IW'(cfg);
        @(posedge clk);
        @(negedge clk);
        if (inject) begin
            start    = 1'b1;
            req_flat = ~rq;
            iter_cfg = IW'(1);
        end else begin
            start = 1'b0;
        end
        while (1) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            cyc++;
            if (done || cyc > N + 2) break;
        end
        got = match_flat;
        chk(done === 1'b1 && cyc == ei, "R5 done after iterations", 64'(cyc), 64'(ei));
        chk(got === em, "R1/R2/R4/R6 match value", 64'(got), 64'(em));
        bad = 1'b0;
        for (int i = 0; i < N; i++) begin
            int rc = 0;
            int cc = 0;
            for (int j = 0; j < N; j++) begin
                rc += int'(got[i*N+j]);
                cc += int'(got[j*N+i]);
            end
            if (rc > 1 || cc > 1) bad = 1'b1;
        end
        if ((got & ~rq) != '0) bad = 1'b1;
        chk(!bad, "R3 conflict-free subset", 64'(got), 64'(rq));
        if (lim == N) begin
            bit nonmax = 1'b0;
            for (int i = 0; i < N; i++)
                for (int j = 0; j < N; j++) begin
                    bit fi = 1'b1;
                    bit fo = 1'b1;
                    for (int x = 0; x < N; x++) begin
                        if (got[i*N+x]) fi = 1'b0;
                        if (got[x*N+j]) fo = 1'b0;
                    end
                    if (rq[i*N+j] && fi && fo) nonmax = 1'b1;
                end
            chk(!nonmax, "R9 maximal", 64'(got), 64'(rq));
        end
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0 && match_flat === got, "R5/R8 held, no second run",
            {63'(match_flat), done}, {63'(got), 1'b0});
    endtask

    function automatic logic [31:0] nxt(input logic [31:0] s);
        return s * 32'd1664525 + 32'd1013904223;
    endfunction

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NN-1:0] got;
        logic [NN-1:0] rq;
        start    = 1'b0;
        iter_cfg = '0;
        req_flat = '0;
        rst_n    = 1'b0;
        for (int i = 0; i < N; i++) begin
            gp[i] = 0;
            ap[i] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && match_flat === '0, "R7 reset state", {63'(match_flat), done}, 64'd0);

        // R10 / R7: full load, one iteration, pointers start at zero.
        for (int s = 0; s < 6; s++) begin
            sched('1, 1, 1'b0, got);
            if (s == 0) chk(got === NN'(1), "R10 R7 first full-load match", 64'(got), 64'd1);
            if (s >= 3) chk(popc(got) == N, "R10 desynchronised full match", 64'(popc(got)), 64'(N));
        end

        // Directed corner patterns.
        sched('0, N, 1'b0, got);
        chk(got === '0, "R5 empty request stops after one iteration", 64'(got), 64'd0);
        for (int b = 0; b < NN; b++) sched(NN'(1) << b, b % (N + 3), 1'b0, got);
        rq = '0;
        for (int i = 0; i < N; i++) rq[i*N + ((i + 1) % N)] = 1'b1;
        sched(rq, N, 1'b0, got);
        chk(got === rq, "R9 permutation fully matched", 64'(got), 64'(rq));
        sched('1, 0, 1'b1, got);
        sched(rq | NN'(16'h00F0), N, 1'b1, got);

        // Pseudo-random sweep: sparse, medium and dense matrices, all limits.
        for (int s = 0; s < 3000; s++) begin
            logic [31:0] a;
            logic [31:0] b;
            lcg = nxt(lcg);
            a   = lcg;
            lcg = nxt(lcg);
            b   = lcg;
            case (s % 3)
                0: rq = NN'(a[31:16] & b[31:16]);
                1: rq = NN'(a[31:16]);
                default: rq = NN'(a[31:16] | b[31:16]);
            endcase
            sched(rq, s % (N + 3), (s % 7) == 0, got);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule